// File: doc/BRIEF.md
# SEC-DED Protected Word Memory Path

This block sits between a simple word-memory requester and a storage array of 39-bit codewords. On a write it expands each 32-bit data word with six Hamming check bits and one overall parity bit. On a read it recomputes the checks. It repairs any single flipped bit before returning the word, and it tells a single-bit error apart from a double-bit error. Each detected error produces a one-cycle event pulse with a type bit, which a scrub engine or a test harness can use.

A sticky error flag summarises the errors the requester cares about. A configuration input selects whether the flag tracks uncorrectable (double) errors only or every detected error. Once the flag is up, ordinary reads do not clear it. Only a deliberate release sequence lowers it: deselect, move to another address, reselect with output enable low, then perform a clean output-enable read. A bypass input switches coding off, so raw data goes straight to and from storage. The array itself lives outside the block. Reads are combinational from the array, and the corrected result is registered.

Read results leave as a `rd_valid` pulse with `rdata`, one cycle after the read is sampled. There is no ready signal and no back-pressure: the consumer must take the word in the cycle it is offered. The stored word is never rewritten on a read, because repair write-back belongs to a scrubber.

Top module: `secded_word_guard`

## Requirements
- R1: A non-bypass write of word D followed by a read of the same address returns D with no error event.
- R2: If exactly one of the 39 stored bits (bit 38 overall parity, bits 37..32 check bits, bits 31..0 data) is flipped, a read returns the original data and pulses `error_event` with `error_type` = 0.
- R3: If two distinct stored bits are flipped, a read pulses `error_event` with `error_type` = 1.
- R4: A read (cs=1, oe=1, we=0) sampled on one rising edge gives `rd_valid` high for exactly the following cycle, with `rdata` and the event outputs valid in that same cycle; `rd_valid` is never high otherwise.
- R5: With `cfg_single_flag` = 0, the flag rises only on a double-bit read; single-bit reads leave it low.
- R6: With `cfg_single_flag` = 1, the flag rises on any detected error, single or double.
- R7: Once high, the flag stays high through further reads, clean or not, until the release sequence of R8 completes.
- R8: The flag falls, in the same cycle as `rd_valid`, after this sequence: at least one cycle with cs=0; cs=1 with oe=0, we=0 and an address different from the last flagged read; then a read whose result is not a flagged error.
- R9: The release is abandoned and the flag stays high if the requester re-selects at the flagged address, re-selects with oe or we high, or writes after re-selecting.
- R10: With `cfg_bypass` = 1, writes store zeros in bits 38..32 and the data in bits 31..0, reads return stored bits 31..0 unmodified, and no error event is produced and the flag does not change.
- R11: After reset `rd_valid`, `error_event` and `err_flag` are low.
- R12: `mem_wr` is high only while cs=1 and we=1; a read never writes the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Select; high enables access |
| we | input | 1 | Write strobe, high writes |
| oe | input | 1 | Output enable, high with we low reads |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| cfg_single_flag | input | 1 | 0: flag on double errors only; 1: flag on any error |
| cfg_bypass | input | 1 | 1: coding disabled, raw pass-through |
| rd_valid | output | 1 | Read result valid (no back-pressure) |
| rdata | output | DATA_W | Corrected or raw read data |
| err_flag | output | 1 | Sticky error flag |
| error_event | output | 1 | One-cycle pulse per detected error |
| error_type | output | 1 | 0 single-bit, 1 double-bit, valid with the event |
| mem_addr | output | ADDR_W | Array address |
| mem_wr | output | 1 | Array write strobe |
| mem_wcode | output | DATA_W+7 | Codeword to store |
| mem_rcode | input | DATA_W+7 | Codeword read from the array |

## Verification
The decoder is driven with a single flip at every one of the 39 codeword positions over changing data patterns. This tells data-bit repair apart from check-bit and parity-bit errors, which must leave the data alone. Double flips and never-written words test detection without correction. The flag is walked through the full release sequence and through each way of breaking it, in both flag modes. Bypass writes and reads with injected data flips show that raw bits pass unchanged and silently.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Smallest check width r with 2^r >= data + r + 1.
  function automatic int chk_width(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Hamming position (1-based, powers of two skipped) of data bit idx.
  function automatic int data_pos(input int idx);
    int n;
    n = 0;
    for (int p = 3; p < 2048; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) return p;
        n++;
      end
    end
    return 0;
  endfunction

  // Data bits covered by check bit k.
  function automatic logic [1023:0] cover_mask(input int dw, input int k);
    logic [1023:0] m;
    m = '0;
    for (int i = 0; i < dw; i++)
      if (((data_pos(i) >> k) & 1) == 1) m[i] = 1'b1;
    return m;
  endfunction

  typedef enum logic [1:0] {
    FL_CLEAR  = 2'd0,
    FL_HELD   = 2'd1,
    FL_OFF    = 2'd2,
    FL_PRIMED = 2'd3
  } flag_state_e;

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CHK_W = chk_width(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [DATA_W-1:0] MASK = DATA_W'(cover_mask(DATA_W, k));
    assign chk[k] = ^(data & MASK);
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CHK_W  = chk_width(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data_out,
  output logic              err_single,
  output logic              err_double
);

  localparam int MAX_POS = DATA_W + CHK_W;

  logic [DATA_W-1:0] raw;
  logic [CHK_W-1:0]  chk_stored;
  logic [CHK_W-1:0]  chk_again;
  logic [CHK_W-1:0]  syn;
  logic              par_bad;
  logic              in_range;

  assign raw        = code[DATA_W-1:0];
  assign chk_stored = code[DATA_W +: CHK_W];

  secded_enc #(.DATA_W(DATA_W)) u_recalc (
    .data (raw),
    .chk  (chk_again)
  );

  assign syn      = chk_stored ^ chk_again;
  assign par_bad  = ^code;
  assign in_range = (int'(syn) <= MAX_POS);

  assign err_single = par_bad && in_range;
  assign err_double = (!par_bad && (syn != '0)) || (par_bad && !in_range);

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam logic [CHK_W-1:0] POS = CHK_W'(data_pos(i));
    assign data_out[i] = raw[i] ^ (par_bad && (syn == POS));
  end

endmodule

// File: rtl/secded_flag_ctrl.sv
module secded_flag_ctrl
  import secded_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_fire,
  input  logic              rd_report,
  output logic              flag
);

  flag_state_e       st_q, st_d;
  logic [ADDR_W-1:0] bad_addr_q;
  logic              capture;

  assign capture = rd_fire && rd_report;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FL_CLEAR:  if (capture) st_d = FL_HELD;
      FL_HELD:   if (!cs) st_d = FL_OFF;
      FL_OFF: begin
        if (cs) begin
          if (!we && !oe && (addr != bad_addr_q)) st_d = FL_PRIMED;
          else                                    st_d = FL_HELD;
        end
      end
      FL_PRIMED: begin
        if (!cs)         st_d = FL_OFF;
        else if (we)     st_d = FL_HELD;
        else if (rd_fire) st_d = rd_report ? FL_HELD : FL_CLEAR;
      end
      default: st_d = FL_CLEAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FL_CLEAR;
      bad_addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (capture) bad_addr_q <= addr;
    end
  end

  assign flag = (st_q != FL_CLEAR);

endmodule

// File: rtl/secded_word_guard.sv
module secded_word_guard
  import secded_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 19,
  localparam int CHK_W  = chk_width(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cfg_single_flag,
  input  logic              cfg_bypass,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              err_flag,
  output logic              error_event,
  output logic              error_type,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [CODE_W-1:0] mem_wcode,
  input  logic [CODE_W-1:0] mem_rcode
);

  logic [CHK_W-1:0]  wchk;
  logic [DATA_W-1:0] fixed;
  logic              e_single, e_double;
  logic              rd_fire, rd_any, rd_report;

  // write path
  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data (wdata),
    .chk  (wchk)
  );

  assign mem_addr  = addr;
  assign mem_wr    = cs && we;
  assign mem_wcode = cfg_bypass ? {{(CHK_W + 1){1'b0}}, wdata}
                                : {^{wdata, wchk}, wchk, wdata};

  // read path
  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .code       (mem_rcode),
    .data_out   (fixed),
    .err_single (e_single),
    .err_double (e_double)
  );

  assign rd_fire   = cs && oe && !we;
  assign rd_any    = !cfg_bypass && (e_single || e_double);
  assign rd_report = !cfg_bypass && (cfg_single_flag ? (e_single || e_double) : e_double);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rdata       <= '0;
      error_event <= 1'b0;
      error_type  <= 1'b0;
    end else begin
      rd_valid    <= rd_fire;
      error_event <= rd_fire && rd_any;
      if (rd_fire) begin
        rdata      <= cfg_bypass ? mem_rcode[DATA_W-1:0] : fixed;
        error_type <= !cfg_bypass && e_double;
      end
    end
  end

  secded_flag_ctrl #(.ADDR_W(ADDR_W)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .we        (we),
    .oe        (oe),
    .addr      (addr),
    .rd_fire   (rd_fire),
    .rd_report (rd_report),
    .flag      (err_flag)
  );

endmodule

// File: rtl/secded_word_guard_chk.sv
module secded_word_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic we,
  input logic oe,
  input logic cfg_single_flag,
  input logic cfg_bypass,
  input logic rd_valid,
  input logic err_flag,
  input logic error_event,
  input logic error_type
);

  AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && oe && !we) |=> rd_valid); // R4
  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cs && oe && !we)); // R4
  AST_EVENT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    error_event |-> rd_valid); // R2
  AST_BYPASS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && oe && !we && cfg_bypass) |=> !error_event); // R10
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (error_event && (error_type || $past(cfg_single_flag)))); // R5
  AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(cs && oe && !we)); // R8
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_flag) && !$past(cs && oe && !we)) |-> err_flag); // R7

endmodule

bind secded_word_guard secded_word_guard_chk u_chk (.*);

// File: tb/secded_word_guard_test.sv
module secded_word_guard_test;

  localparam int AW = 8;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, we = 0, oe = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic mode = 0, byp = 0;
  logic rd_valid, err_flag, error_event, error_type, mem_wr;
  logic [31:0] rdata;
  logic [AW-1:0] mem_addr;
  logic [38:0] mem_wcode, mem_rcode;

  always #2 clk = ~clk; // 250 MHz

  secded_word_guard #(.DATA_W(32), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .oe(oe), .addr(addr),
    .wdata(wdata), .cfg_single_flag(mode), .cfg_bypass(byp),
    .rd_valid(rd_valid), .rdata(rdata), .err_flag(err_flag),
    .error_event(error_event), .error_type(error_type),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wcode(mem_wcode),
    .mem_rcode(mem_rcode)
  );

  // behavioural storage array
  logic [38:0] mem [DEPTH];
  assign mem_rcode = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wcode;

  // reference bookkeeping
  logic [31:0] gold [DEPTH];
  int nflip [DEPTH];
  bit written [DEPTH];
  int m_st = 0;            // 0 clear, 1 held, 2 off, 3 primed
  logic [AW-1:0] m_bad = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic o,
                      input logic [AW-1:0] a, input logic [31:0] d, input string req);
    bit rd, ev, rep, dchk;
    int n;
    logic [31:0] edata;
    @(negedge clk);
    cs = c; we = w; oe = o; addr = a; wdata = d;
    #0.5;
    chk("R12 mem_wr", {31'b0, mem_wr}, {31'b0, c && w});
    if (c && w && byp) chk("R10 upper bits", {25'b0, mem_wcode[38:32]}, 32'b0);
    rd = c && o && !w;
    n = written[a] ? nflip[a] : 2;
    ev = rd && !byp && n >= 1;
    rep = rd && !byp && (mode ? n >= 1 : n >= 2);
    dchk = rd && (byp || n <= 1);
    edata = byp ? mem[a][31:0] : gold[a];
    // flag model
    case (m_st)
      0: if (rep) begin m_st = 1; m_bad = a; end
      1: begin if (rep) m_bad = a; if (!c) m_st = 2; end
      2: if (c) begin
           m_st = (!w && !o && a != m_bad) ? 3 : 1;
           if (rep) m_bad = a;
         end
      default: if (!c) m_st = 2;
               else if (w) m_st = 1;
               else if (rd) begin m_st = rep ? 1 : 0; if (rep) m_bad = a; end
    endcase
    if (c && w) begin gold[a] = d; nflip[a] = 0; written[a] = 1; end
    @(posedge clk); #1;
    chk({req, " rd_valid R4"}, {31'b0, rd_valid}, {31'b0, rd});
    chk({req, " event"}, {31'b0, error_event}, {31'b0, ev});
    if (ev) chk({req, " type"}, {31'b0, error_type}, {31'b0, n >= 2});
    if (dchk) chk({req, " data"}, rdata, edata);
    chk({req, " flag"}, {31'b0, err_flag}, {31'b0, m_st != 0});
  endtask

  task automatic flip(input logic [AW-1:0] a, input int b);
    mem[a][b] = ~mem[a][b];
    nflip[a]++;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string r);
    step(1, 1, 0, a, d, r);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string r);
    step(1, 0, 1, a, 32'h0, r);
  endtask
  task automatic idle(input string r);
    step(0, 0, 0, 0, 32'h0, r);
  endtask
  task automatic release_seq(input logic [AW-1:0] good, input string r);
    idle(r);
    step(1, 0, 0, good, 32'h0, r);
    rd(good, r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 39'h3; gold[i] = '0; nflip[i] = 0; written[i] = 0;
    end
    #1;
    chk("R11 reset valid", {31'b0, rd_valid}, 32'b0);
    chk("R11 reset flag", {31'b0, err_flag}, 32'b0);
    chk("R11 reset event", {31'b0, error_event}, 32'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    idle("R11 idle");

    // R1 clean round trips
    wr(0, 32'h0000_0000, "R1"); wr(1, 32'hFFFF_FFFF, "R1");
    wr(2, 32'hA5A5_5A5A, "R1"); wr(3, 32'h8000_0001, "R1");
    for (int i = 4; i < 8; i++) wr(i[AW-1:0], 32'h1 << (i * 7), "R1");
    for (int i = 0; i < 8; i++) rd(i[AW-1:0], "R1");

    // R2 single flips at every stored position, R5 flag stays low in mode 0
    lfsr = 32'hC0DE_1234;
    for (int b = 0; b < 39; b++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr(10, lfsr, "R2");
      flip(10, b);
      rd(10, "R2 R5");
    end

    // R3 double flip raises flag in mode 0 (R5)
    wr(11, 32'h1357_9BDF, "R3");
    flip(11, 3); flip(11, 20);
    rd(11, "R3 R5");
    rd(0, "R7 clean read keeps flag");
    rd(11, "R7 repeat");

    // R9 broken sequences
    idle("R9"); step(1, 0, 0, 11, 0, "R9 same addr"); rd(0, "R9");
    idle("R9"); rd(0, "R9 oe at reselect");
    idle("R9"); step(1, 0, 0, 0, 0, "R9"); wr(30, 32'h55AA_55AA, "R9 write"); rd(0, "R9");
    // unwritten word read
    rd(200, "R3 unwritten");

    // R8 correct release
    release_seq(0, "R8");
    rd(0, "R8 stays clear");

    // R6 mode 1
    mode = 1;
    wr(12, 32'hDEAD_BEEF, "R6");
    flip(12, 17);
    rd(12, "R6 single sets flag");
    release_seq(1, "R8 mode1");
    rd(11, "R6 double sets flag");
    release_seq(2, "R8 mode1 again");
    mode = 0;

    // R10 bypass
    byp = 1;
    wr(20, 32'h0F0F_F0F0, "R10");
    flip(20, 5);
    rd(20, "R10 raw flipped data");
    rd(11, "R10 no event on bad word");
    byp = 0;
    rd(0, "R1 after bypass");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule